// File: doc/BRIEF.md
# Timed-Eviction Circular Queue

A single-clock queue of fixed depth placed between a producer with hard timing and a consumer that may stall for a while. Writes that find room enter at once. A write that meets a full queue is not refused at once. It is held in a single side register for a number of cycles that the producer gives with the write. If the consumer reads during that window, the held write enters the queue. If the window closes first, the block does one of two things. In evict mode it replaces the oldest stored entry with the held data. In discard mode it throws the held data away. Either way, a one-cycle timeout pulse reports the event.

Reads are requests. A granted read returns the head entry through a registered data output one cycle later, together with a valid strobe. The occupancy count, the full flag, the empty flag and the pending-write flag are all visible at the ports.

Top module: `tq_top`

## Requirements
- R1: Entries leave in the exact order they were accepted, and every entry is DATA_W bits wide.
- R2: A write and a read may happen in the same cycle, including on a full queue. The write is accepted, the head is returned, and the count is unchanged.
- R3: count_o never exceeds DEPTH. full_o is high exactly when count_o equals DEPTH. Writes into a queue that is not full leave earlier entries intact.
- R4: A write (wr_valid_i high) that meets a full queue with no read in that cycle, and a non-zero tmo_cycles_i, raises pend_o at the next edge. The data, mode and timeout value are captured at that point. wr_valid_i is ignored while pend_o is high.
- R5: A read in any cycle while pend_o is high moves the held data into the queue at that same edge. pend_o then drops, tmo_o stays low and count_o stays at DEPTH.
- R6: With timeout N ≥ 1 and no read, the decision is taken N edges after pend_o rose. tmo_o is high for exactly the cycle after that decision.
- R7: In evict mode (ovw_en_i = 1) the decision replaces the oldest entry with the held data. count_o stays at DEPTH, and the next read returns the entry that was second oldest.
- R8: In discard mode (ovw_en_i = 0) the decision drops the held data and leaves the contents and count unchanged.
- R9: tmo_cycles_i = 0 on a write to a full queue with no read makes the evict or discard decision at that same edge. tmo_o pulses and pend_o never rises.
- R10: A read request on an empty queue keeps empty_o high, gives rd_valid_o = 0 in the next cycle, and changes no state.
- R11: rst_ni low empties the queue, clears any pending write and lowers tmo_o and rd_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| ovw_en_i | input | 1 | 1: evict oldest on timeout, 0: discard write |
| tmo_cycles_i | input | TMO_W | Cycles to hold a write that found the queue full |
| rd_req_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Data of the last granted read |
| rd_valid_o | output | 1 | rd_data_o is from a read granted in the previous cycle |
| empty_o | output | 1 | Queue holds no entries |
| full_o | output | 1 | Queue holds DEPTH entries |
| count_o | output | $clog2(DEPTH+1) | Occupancy |
| pend_o | output | 1 | A write is held waiting for a slot |
| tmo_o | output | 1 | One-cycle pulse after an evict or discard decision |

## Verification
The bench builds the block with DATA_W = 8, DEPTH = 4 and TMO_W = 4. At this depth the queue fills in a few writes, so the vector table can reach every full-queue path in a short run:
- held writes that are later rescued by a read,
- timeouts of one and two cycles,
- zero-timeout eviction and discard,
- read and write together on a full queue.

Pointer wrap is crossed several times along the way. The eviction and discard outcomes are then confirmed by draining the queue and comparing the exact order of the values that come out.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_PUSH  = 2'd1,
    ACT_EVICT = 2'd2
  } wr_act_e;
endpackage

// File: rtl/tq_ring.sv
module tq_ring
  import tq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_act_e           act_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;
  logic              push, evict, adv_rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push    = (act_i != ACT_NONE);
  assign evict   = (act_i == ACT_EVICT);
  assign adv_rp  = pop_i | evict;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign rdata_o = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push)   wp_q <= nxt(wp_q);
      if (adv_rp) rp_q <= nxt(rp_q);
      if (push && !pop_i && !evict) cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push)      cnt_q <= cnt_q - CW'(1);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_push_needs_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && full_o && !pop_i) |-> evict);
  p_no_pop_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_evict_keeps_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict |=> full_o);
endmodule

// File: rtl/tq_wr_ctrl.sv
module tq_wr_ctrl
  import tq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ovw_en_i,
  input  logic [TMO_W-1:0]  tmo_cycles_i,
  input  logic              full_i,
  input  logic              pop_i,
  output wr_act_e           act_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              pend_o,
  output logic              tmo_o
);
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pdata_q, pdata_d;
  logic              povw_q, povw_d;
  logic [TMO_W-1:0]  tcnt_q, tcnt_d;
  logic              tmo_q, tmo_d;

  always_comb begin
    act_o   = ACT_NONE;
    wdata_o = wr_data_i;
    pend_d  = pend_q;
    pdata_d = pdata_q;
    povw_d  = povw_q;
    tcnt_d  = tcnt_q;
    tmo_d   = 1'b0;
    if (pend_q) begin
      wdata_o = pdata_q;
      if (pop_i || !full_i) begin
        act_o  = ACT_PUSH;
        pend_d = 1'b0;
      end else if (tcnt_q <= TMO_W'(1)) begin
        act_o  = povw_q ? ACT_EVICT : ACT_NONE;
        tmo_d  = 1'b1;
        pend_d = 1'b0;
      end else begin
        tcnt_d = tcnt_q - TMO_W'(1);
      end
    end else if (wr_valid_i) begin
      if (!full_i || pop_i) begin
        act_o = ACT_PUSH;
      end else if (tmo_cycles_i == '0) begin
        // zero wait: decide on this edge
        act_o = ovw_en_i ? ACT_EVICT : ACT_NONE;
        tmo_d = 1'b1;
      end else begin
        pend_d  = 1'b1;
        pdata_d = wr_data_i;
        povw_d  = ovw_en_i;
        tcnt_d  = tmo_cycles_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pdata_q <= '0;
      povw_q  <= 1'b0;
      tcnt_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pdata_q <= pdata_d;
      povw_q  <= povw_d;
      tcnt_q  <= tcnt_d;
      tmo_q   <= tmo_d;
    end
  end

  assign pend_o = pend_q;
  assign tmo_o  = tmo_q;

  p_pend_only_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> full_i);
  p_read_rescues_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && pop_i) |=> (!pend_q && !tmo_q));
  p_tmo_ends_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |-> !pend_q);
endmodule

// File: rtl/tq_top.sv
module tq_top
  import tq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int TMO_W  = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ovw_en_i,
  input  logic [TMO_W-1:0]  tmo_cycles_i,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CW-1:0]     count_o,
  output logic              pend_o,
  output logic              tmo_o
);
  wr_act_e           act;
  logic [DATA_W-1:0] wdata, head;
  logic              pop;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  assign pop = rd_req_i & ~empty_o;

  tq_wr_ctrl #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_valid_i, .wr_data_i, .ovw_en_i, .tmo_cycles_i,
    .full_i(full_o), .pop_i(pop), .act_o(act), .wdata_o(wdata),
    .pend_o, .tmo_o
  );

  tq_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni, .act_i(act), .wdata_i(wdata), .pop_i(pop),
    .rdata_o(head), .count_o, .full_o, .empty_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= pop;
      if (pop) rd_data_q <= head;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;

  p_empty_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && empty_o) |=> !rd_valid_o);
  p_idle_keeps_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == ACT_NONE && !pop) |=> $stable(count_o));
  p_rw_full_keeps_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && pop && act == ACT_PUSH) |=> full_o);
endmodule

// File: tb/tq_top_tb_top.sv
`timescale 1ns/1ps
module tq_top_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int TMO_W  = 4;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int NV     = 25;

  typedef struct packed {
    logic        wv;
    logic        ov;
    logic [3:0]  tm;
    logic [7:0]  wd;
    logic        rd;
    logic        erv;
    logic [7:0]  erd;
    logic [2:0]  ecnt;
    logic        ep;
    logic        et;
    logic [3:0]  req;
  } vec_t;

  // wv ov tm wd rd | erv erd cnt pend tmo req
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,4'd0,8'h11,1'b0, 1'b0,8'h00,3'd1,1'b0,1'b0,4'd3}, // R3
    '{1'b1,1'b0,4'd0,8'h22,1'b0, 1'b0,8'h00,3'd2,1'b0,1'b0,4'd3},
    '{1'b1,1'b0,4'd0,8'h33,1'b1, 1'b1,8'h11,3'd2,1'b0,1'b0,4'd2}, // R2 rw
    '{1'b1,1'b0,4'd0,8'h44,1'b0, 1'b0,8'h00,3'd3,1'b0,1'b0,4'd3},
    '{1'b1,1'b0,4'd0,8'h55,1'b0, 1'b0,8'h00,3'd4,1'b0,1'b0,4'd3},
    '{1'b1,1'b1,4'd2,8'h66,1'b0, 1'b0,8'h00,3'd4,1'b1,1'b0,4'd4}, // R4 hold
    '{1'b1,1'b0,4'd0,8'hEE,1'b0, 1'b0,8'h00,3'd4,1'b1,1'b0,4'd4}, // R4 ignored
    '{1'b0,1'b0,4'd0,8'h00,1'b0, 1'b0,8'h00,3'd4,1'b0,1'b1,4'd6}, // R6 R7 evict
    '{1'b0,1'b0,4'd0,8'h00,1'b1, 1'b1,8'h33,3'd3,1'b0,1'b0,4'd7}, // R7 second oldest
    '{1'b1,1'b0,4'd3,8'h77,1'b0, 1'b0,8'h00,3'd4,1'b0,1'b0,4'd3},
    '{1'b1,1'b0,4'd1,8'h88,1'b0, 1'b0,8'h00,3'd4,1'b1,1'b0,4'd4},
    '{1'b0,1'b0,4'd0,8'h00,1'b0, 1'b0,8'h00,3'd4,1'b0,1'b1,4'd8}, // R8 drop
    '{1'b0,1'b0,4'd0,8'h00,1'b1, 1'b1,8'h44,3'd3,1'b0,1'b0,4'd8},
    '{1'b1,1'b0,4'd0,8'h99,1'b0, 1'b0,8'h00,3'd4,1'b0,1'b0,4'd3},
    '{1'b1,1'b1,4'd3,8'hAA,1'b0, 1'b0,8'h00,3'd4,1'b1,1'b0,4'd4},
    '{1'b0,1'b0,4'd0,8'h00,1'b1, 1'b1,8'h55,3'd4,1'b0,1'b0,4'd5}, // R5 rescue
    '{1'b0,1'b0,4'd0,8'h00,1'b0, 1'b0,8'h00,3'd4,1'b0,1'b0,4'd5},
    '{1'b1,1'b1,4'd0,8'hBB,1'b0, 1'b0,8'h00,3'd4,1'b0,1'b1,4'd9}, // R9 evict now
    '{1'b1,1'b0,4'd0,8'hCC,1'b0, 1'b0,8'h00,3'd4,1'b0,1'b1,4'd9}, // R9 drop now
    '{1'b1,1'b0,4'd0,8'hDD,1'b1, 1'b1,8'h77,3'd4,1'b0,1'b0,4'd2}, // R2 on full
    '{1'b0,1'b0,4'd0,8'h00,1'b1, 1'b1,8'h99,3'd3,1'b0,1'b0,4'd1}, // R1 drain
    '{1'b0,1'b0,4'd0,8'h00,1'b1, 1'b1,8'hAA,3'd2,1'b0,1'b0,4'd1},
    '{1'b0,1'b0,4'd0,8'h00,1'b1, 1'b1,8'hBB,3'd1,1'b0,1'b0,4'd1},
    '{1'b0,1'b0,4'd0,8'h00,1'b1, 1'b1,8'hDD,3'd0,1'b0,1'b0,4'd1},
    '{1'b0,1'b0,4'd0,8'h00,1'b1, 1'b0,8'h00,3'd0,1'b0,1'b0,4'd10} // R10
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_valid_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              ovw_en_i = 1'b0;
  logic [TMO_W-1:0]  tmo_cycles_i = '0;
  logic              rd_req_i = 1'b0;
  logic [DATA_W-1:0] rd_data_o;
  logic              rd_valid_o, empty_o, full_o, pend_o, tmo_o;
  logic [CW-1:0]     count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  tq_top #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TMO_W(TMO_W)) dut_i (
    .clk_i, .rst_ni, .wr_valid_i, .wr_data_i, .ovw_en_i, .tmo_cycles_i,
    .rd_req_i, .rd_data_o, .rd_valid_o, .empty_o, .full_o, .count_o,
    .pend_o, .tmo_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic wv, input logic ov, input logic [3:0] tm,
                       input logic [7:0] wd, input logic rd);
    wr_valid_i = wv; ovw_en_i = ov; tmo_cycles_i = tm; wr_data_i = wd; rd_req_i = rd;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #25;
    chk("R11", "count at reset", int'(count_o), 0);
    chk("R11", "empty at reset", int'(empty_o), 1);
    chk("R11", "pend at reset", int'(pend_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d v%0d", VECS[i].req, i);
      drive(VECS[i].wv, VECS[i].ov, VECS[i].tm, VECS[i].wd, VECS[i].rd);
      step();
      chk(tag, "rd_valid", int'(rd_valid_o), int'(VECS[i].erv));
      if (VECS[i].erv) chk(tag, "rd_data", int'(rd_data_o), int'(VECS[i].erd));
      chk(tag, "count", int'(count_o), int'(VECS[i].ecnt));
      chk(tag, "pend", int'(pend_o), int'(VECS[i].ep));
      chk(tag, "tmo", int'(tmo_o), int'(VECS[i].et));
      chk(tag, "full", int'(full_o), int'(VECS[i].ecnt == 3'd4));
      chk(tag, "empty", int'(empty_o), int'(VECS[i].ecnt == 3'd0));
    end
    drive(1'b0, 1'b0, 4'd0, 8'h00, 1'b0);

    // R10: empty read leaves empty, no valid
    drive(1'b0, 1'b0, 4'd0, 8'h00, 1'b1);
    chk("R10", "empty before edge", int'(empty_o), 1);
    step();
    chk("R10", "rd_valid", int'(rd_valid_o), 0);
    chk("R10", "count", int'(count_o), 0);
    drive(1'b0, 1'b0, 4'd0, 8'h00, 1'b0);

    // R11: reset while a write is held
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b1, 1'b0, 4'd5, 8'(8'h30 + k), 1'b0);
      step();
    end
    drive(1'b1, 1'b1, 4'd5, 8'hF0, 1'b0);
    step();
    drive(1'b0, 1'b0, 4'd0, 8'h00, 1'b0);
    chk("R4", "pend before reset", int'(pend_o), 1);
    rst_ni = 1'b0;
    #1;
    chk("R11", "count in reset", int'(count_o), 0);
    chk("R11", "pend in reset", int'(pend_o), 0);
    chk("R11", "empty in reset", int'(empty_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk("R11", "no leaked write", int'(count_o), 0);
    drive(1'b1, 1'b0, 4'd0, 8'h5A, 1'b0);
    step();
    drive(1'b0, 1'b0, 4'd0, 8'h00, 1'b1);
    step();
    drive(1'b0, 1'b0, 4'd0, 8'h00, 1'b0);
    chk("R11", "post-reset readback", int'(rd_data_o), 8'h5A);
    chk("R11", "post-reset valid", int'(rd_valid_o), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule